// File: doc/BRIEF.md
# Nibble RAM Access Executor

This block executes the small group of instructions that a 4-bit processor uses to reach its nibble-wide data RAM. It holds a 4-bit accumulator and a file of sixteen 4-bit registers grouped into eight pairs. Instruction bytes arrive one at a time on a byte-wide input, qualified by a valid strobe. The RAM is never addressed directly. A pair is first loaded with an immediate byte. A separate instruction then copies that pair into an address latch. A later write stores the accumulator at the latched address, in whichever bank was chosen last.

The RAM side is a plain parallel interface. It carries the latched address, the accumulator as write data, one select line per bank and a single-cycle write strobe. The bank lines come from the accumulator bits when the bank-select instruction runs. The lowest line is asserted only when the three bank bits are all clear. Any other pattern drives the upper three lines straight from those bits, so an external decoder can turn them into up to eight banks.

Top module: `nib_ram_exec`

## Requirements
- R1: After reset, ram_addr is 0x00, ram_data is 0, ram_bank_sel is 4'b0001 (bank 0), and ram_we and illegal_op are low.
- R2: Byte 0x20|(p<<1), with p in 0..7, starts a two-byte load of pair p. The next accepted byte is taken as data, never decoded as an opcode. Its upper nibble goes to register 2p and its lower nibble to register 2p+1. Nothing else changes.
- R3: Byte 0x21|(p<<1) sets ram_addr to {R(2p), R(2p+1)}, with the even register as the high nibble. The new value appears in the cycle after the byte is accepted.
- R4: Byte 0xDn loads n into the accumulator. ram_data shows the accumulator from the cycle after acceptance.
- R5: Byte 0xE0 raises ram_we for exactly one cycle, the cycle after acceptance. During that cycle ram_addr and ram_data hold the latched address and the accumulator.
- R6: Byte 0xFD sets ram_bank_sel from accumulator bits [2:0]. The value 000 gives 4'b0001. Any other value v gives {v, 1'b0}. Accumulator bit 3 is ignored. The lines change only through this instruction.
- R7: A byte presented while instr_valid is low has no effect.
- R8: Any other opcode byte pulses illegal_op for one cycle and leaves all state unchanged. The remaining opcodes are 0x00-0x1F, 0x30-0xCF, 0xE1-0xFC, 0xFE and 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | instr_byte is accepted at this edge |
| instr_byte | input | 8 | Opcode or immediate byte |
| ram_addr | output | 8 | Latched RAM address |
| ram_data | output | 4 | Write data (accumulator) |
| ram_bank_sel | output | 4 | Bank select lines |
| ram_we | output | 1 | One-cycle write strobe |
| illegal_op | output | 1 | One-cycle pulse on an unsupported opcode |

## Verification
Every result is registered at the edge that accepts the byte. The address, data, bank lines, write strobe and illegal flag are therefore all due one cycle after acceptance. The bench drives a byte after a falling edge and waits for the next rising edge. It samples one nanosecond later, so each step compares the outputs against the model updated by exactly that byte. Idle steps with the strobe low confirm that the write and illegal pulses last only one cycle, and that nothing moves without a valid byte.

// File: rtl/nib_pkg.sv
package nib_pkg;
    typedef enum logic [2:0] {
        OP_NOP,
        OP_LDPAIR,
        OP_SEND,
        OP_LDACC,
        OP_WRITE,
        OP_BANK,
        OP_BAD
    } nib_op_e;
endpackage

// File: rtl/nib_decode.sv
module nib_decode #(
    parameter int NREG = 16,
    localparam int PW = $clog2(NREG / 2)
) (
    input  logic [7:0]       opc,
    output nib_pkg::nib_op_e op,
    output logic [PW-1:0]    pair,
    output logic [3:0]       imm
);
    import nib_pkg::*;

    always_comb begin
        pair = opc[PW:1];
        imm  = opc[3:0];
        unique case (opc[7:4])
            4'h2:    op = opc[0] ? OP_SEND : OP_LDPAIR;
            4'hD:    op = OP_LDACC;
            4'hE:    op = (opc[3:0] == 4'h0) ? OP_WRITE : OP_BAD;
            4'hF:    op = (opc[3:0] == 4'hD) ? OP_BANK : OP_BAD;
            default: op = OP_BAD;
        endcase
    end
endmodule

// File: rtl/nib_bank_dec.sv
module nib_bank_dec #(
    parameter int DW    = 4,
    parameter int NLINE = 4
) (
    input  logic [DW-1:0]    acc,
    output logic [NLINE-1:0] sel
);
    // Upper lines follow accumulator bits; line 0 only when those are all clear.
    assign sel[0] = (acc[NLINE-2:0] == '0);
    for (genvar i = 1; i < NLINE; i++) begin : g_line
        assign sel[i] = acc[i-1];
    end

    always_comb begin
        assert_line0_excl_R6: assert (!sel[0] || (sel[NLINE-1:1] == '0));
    end
endmodule

// File: rtl/nib_ram_exec.sv
module nib_ram_exec #(
    parameter int DW    = 4,
    parameter int NREG  = 16,
    parameter int NLINE = 4,
    localparam int AW   = 2 * DW,
    localparam int PW   = $clog2(NREG / 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [7:0]       instr_byte,
    output logic [AW-1:0]    ram_addr,
    output logic [DW-1:0]    ram_data,
    output logic [NLINE-1:0] ram_bank_sel,
    output logic             ram_we,
    output logic             illegal_op
);
    import nib_pkg::*;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic [DW-1:0]           acc;
        logic [AW-1:0]           addr;
        logic [NLINE-1:0]        sel;
        logic                    pend;
        logic [PW-1:0]           pend_pair;
        logic                    we;
        logic                    bad;
    } exec_state_t;

    exec_state_t s_d, s_q;

    nib_op_e          dec_op;
    logic [PW-1:0]    dec_pair;
    logic [3:0]       dec_imm;
    logic [NLINE-1:0] bank_next;

    nib_decode #(.NREG(NREG)) u_decode (
        .opc  (instr_byte),
        .op   (dec_op),
        .pair (dec_pair),
        .imm  (dec_imm)
    );

    nib_bank_dec #(.DW(DW), .NLINE(NLINE)) u_bank (
        .acc (s_q.acc),
        .sel (bank_next)
    );

    logic take_op;
    assign take_op = instr_valid && !s_q.pend;

    always_comb begin
        s_d     = s_q;
        s_d.we  = 1'b0;
        s_d.bad = 1'b0;
        if (instr_valid && s_q.pend) begin
            s_d.regs[{s_q.pend_pair, 1'b0}] = instr_byte[2*DW-1:DW];
            s_d.regs[{s_q.pend_pair, 1'b1}] = instr_byte[DW-1:0];
            s_d.pend = 1'b0;
        end else if (take_op) begin
            unique case (dec_op)
                OP_LDPAIR: begin
                    s_d.pend      = 1'b1;
                    s_d.pend_pair = dec_pair;
                end
                OP_SEND:  s_d.addr = {s_q.regs[{dec_pair, 1'b0}], s_q.regs[{dec_pair, 1'b1}]};
                OP_LDACC: s_d.acc  = dec_imm[DW-1:0];
                OP_WRITE: s_d.we   = 1'b1;
                OP_BANK:  s_d.sel  = bank_next;
                OP_BAD:   s_d.bad  = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.sel <= NLINE'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign ram_addr     = s_q.addr;
    assign ram_data     = s_q.acc;
    assign ram_bank_sel = s_q.sel;
    assign ram_we       = s_q.we;
    assign illegal_op   = s_q.bad;

    assert_we_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($past(take_op && dec_op == OP_WRITE) && $stable(ram_addr) && $stable(ram_data)));

    assert_addr_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ram_addr) |-> $past(take_op && dec_op == OP_SEND));

    assert_pend_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && instr_valid) |=> (!s_q.pend && !ram_we && !illegal_op));

    assert_bad_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> ($stable(s_q.regs) && $stable(ram_data) && $stable(ram_addr)
                        && $stable(ram_bank_sel) && !s_q.pend));

    assert_sel_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ram_bank_sel) != 0);
endmodule

// File: tb/nib_ram_exec_tb.sv
module nib_ram_exec_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [7:0] instr_byte = 8'h00;
    logic [7:0] ram_addr;
    logic [3:0] ram_data;
    logic [3:0] ram_bank_sel;
    logic       ram_we;
    logic       illegal_op;

    int n_chk = 0;
    int n_fail = 0;

    logic [3:0] m_regs [16];
    logic [3:0] m_acc;
    logic [7:0] m_addr;
    logic [3:0] m_sel;
    logic       m_pend;
    logic [2:0] m_pair;
    logic       e_we, e_bad;

    always #5 clk = ~clk;

    nib_ram_exec u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_valid  (instr_valid),
        .instr_byte   (instr_byte),
        .ram_addr     (ram_addr),
        .ram_data     (ram_data),
        .ram_bank_sel (ram_bank_sel),
        .ram_we       (ram_we),
        .illegal_op   (illegal_op)
    );

    // 1 load pair, 2 send, 3 load acc, 4 write, 5 bank, 6 unsupported
    function automatic int kind_of(input logic [7:0] b);
        if (b[7:4] == 4'h2) return b[0] ? 2 : 1;
        if (b[7:4] == 4'hD) return 3;
        if (b == 8'hE0) return 4;
        if (b == 8'hFD) return 5;
        return 6;
    endfunction

    function automatic logic [3:0] lines_of(input logic [3:0] a);
        return (a[2:0] == 3'b000) ? 4'b0001 : {a[2:0], 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_regs[i] = 4'h0;
        m_acc = 0; m_addr = 0; m_sel = 4'b0001; m_pend = 0; m_pair = 0;
        e_we = 0; e_bad = 0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " addr"}, 32'(ram_addr), 32'(m_addr));
        chk({tag, " data"}, 32'(ram_data), 32'(m_acc));
        chk({tag, " bank"}, 32'(ram_bank_sel), 32'(m_sel));
        chk({tag, " we"}, 32'(ram_we), 32'(e_we));
        chk({tag, " illegal"}, 32'(illegal_op), 32'(e_bad));
    endtask

    task automatic step(input logic v, input logic [7:0] b);
        string tag;
        @(negedge clk);
        instr_valid = v;
        instr_byte  = b;
        e_we = 0; e_bad = 0;
        tag = "R7";
        if (v) begin
            if (m_pend) begin
                m_regs[{m_pair, 1'b0}] = b[7:4];
                m_regs[{m_pair, 1'b1}] = b[3:0];
                m_pend = 0;
                tag = "R2";
            end else begin
                case (kind_of(b))
                    1: begin m_pend = 1; m_pair = b[3:1]; tag = "R2"; end
                    2: begin m_addr = {m_regs[{b[3:1], 1'b0}], m_regs[{b[3:1], 1'b1}]}; tag = "R3"; end
                    3: begin m_acc = b[3:0]; tag = "R4"; end
                    4: begin e_we = 1; tag = "R5"; end
                    5: begin m_sel = lines_of(m_acc); tag = "R6"; end
                    default: begin e_bad = 1; tag = "R8"; end
                endcase
            end
        end
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    function automatic logic [7:0] pick_byte(input int sel);
        logic [7:0] b;
        case (sel)
            0: b = {4'h2, 3'($urandom), 1'b0};
            1: b = {4'h2, 3'($urandom), 1'b1};
            2: b = {4'hD, 4'($urandom)};
            3: b = 8'hE0;
            4: b = 8'hFD;
            5: begin
                b = 8'($urandom);
                while (kind_of(b) != 6) b = 8'($urandom);
            end
            default: b = 8'($urandom);
        endcase
        return b;
    endfunction

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // Directed write sequence: address 0x09, value 7
        step(1, 8'h20); step(1, 8'h09);
        step(1, 8'h21); step(1, 8'hD7);
        step(1, 8'hE0);
        step(0, 8'hE0);              // R5 pulse ended, R7 no effect
        // Data byte 0xE0 of a pair load is not a write (R2)
        step(1, 8'h2E); step(1, 8'hE0);
        step(1, 8'h2F);              // R3 address 0xE0, even register high
        // Bank line patterns (R6)
        step(1, 8'hD3); step(1, 8'hFD);
        step(1, 8'hD8); step(1, 8'hFD);
        step(1, 8'hD7); step(1, 8'hFD);
        step(1, 8'hD0); step(1, 8'hFD);
        // Unsupported codes (R8)
        step(1, 8'hE1); step(1, 8'hFF); step(1, 8'hFE); step(1, 8'h1F);
        step(1, 8'hE0);
        step(0, 8'hD5); step(0, 8'h21);

        for (int i = 0; i < 3000; i++) begin
            int s;
            s = int'($urandom % 8);
            if (s == 7) step(0, 8'($urandom));
            else        step(1, pick_byte(s));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule